// File: doc/BRIEF.md
# Addressed Serial Display-Data Receiver

This block receives display and control data over a three-wire serial link (chip enable, serial clock, serial data) and keeps the last accepted values in holding registers for a segment display controller. A transfer begins with an 8-bit device address, shifted in while chip enable is low. The data phase follows with chip enable high. The last data bit is a direction bit, and it selects which of two frame slots the data belongs to. Slot A carries the first 28 display bits and the control fields. Slot B carries the remaining 26 display bits.

The link pins are sampled by the system clock, and edges on them are detected inside the block. A frame is accepted only if the address matched and the number of data bits is exactly the slot length for the current format. Acceptance happens when chip enable falls. Any other frame is discarded and leaves the outputs unchanged.

A static pin selects between two transfer formats. The standard format uses 40 data bits per slot. The compact format uses 32 data bits per slot, and in compact format the mode controls are held at fixed values. The block has no streaming interface: its serial pins, format pin and decoded outputs are all plain levels, so there is no back-pressure to manage.

Top module: `seg_rx`

## Requirements
- R1: After reset, `disp`, `seg_blank` and `pwr_save` are 0. With `fmt_compact` low, `port_sel`, `duty_half`, `frame_code` and `osc_stop` are also 0.
- R2: The address is shifted in on rising `cl` edges while `ce` is low, least significant bit first. A frame is accepted only when the 8 bits seen before `ce` rises equal 0x44 (on the wire: 0,0,1,0,0,0,1,0). Any other address leaves every output unchanged.
- R3: In a standard slot-A frame, data bit k is the k-th bit sent after `ce` rises, starting at k=0. Bits 0..27 go to `disp[27:0]`. Bit 28 is ignored. Bits 29..31 go to `port_sel[2:0]` and bit 32 goes to `duty_half`. Bits 33..35 go to `frame_code[2:0]`. Bits 36, 37 and 38 go to `osc_stop`, `seg_blank` and `pwr_save`. Bit 39 is the direction bit and is 0.
- R4: In a standard slot-B frame (bit 39 = 1), bits 0..25 go to `disp[53:28]`. Bits 26..38 are ignored, and the control outputs keep their values.
- R5: In compact format a slot is 32 bits, with the direction bit at bit 31. In slot A, bits 0..27 go to `disp[27:0]`, bit 28 goes to `pwr_save` and bit 29 goes to `seg_blank`. In slot B, bits 0..25 go to `disp[53:28]`.
- R6: While `fmt_compact` is high, `port_sel`=0, `duty_half`=1, `frame_code`=0 and `osc_stop`=0, regardless of the frames received.
- R7: A frame whose bit count differs from the slot length of the current format (40 standard, 32 compact) is discarded.
- R8: A slot-A update leaves `disp[53:28]` unchanged, and a slot-B update leaves `disp[27:0]` unchanged.
- R9: The outputs change only as the result of a falling `ce` edge. They stay stable while a frame is being shifted in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the link pins |
| rst | input | 1 | Synchronous active-high reset |
| fmt_compact | input | 1 | Static format select: 1 = compact, 0 = standard |
| ce | input | 1 | Chip enable: low for the address, high for the data |
| cl | input | 1 | Serial clock; data is taken on its rising edge |
| di | input | 1 | Serial data |
| disp | output | 54 | Display bits: slot A in [27:0], slot B in [53:28] |
| port_sel | output | 3 | Shared-pin function select field |
| duty_half | output | 1 | Duty select: 1 = half duty |
| frame_code | output | 3 | Frame-rate divisor code |
| osc_stop | output | 1 | Oscillator control bit |
| seg_blank | output | 1 | Segments-off control bit |
| pwr_save | output | 1 | Power-saving mode bit |

## Verification
Each pin change is captured by one input register and compared against a second register for edge detection. The resulting edge strobe acts on the following clock. So a falling `ce` appears on the holding outputs at the second rising clock edge after the pin changes, while `fmt_compact` affects the forced fields combinationally. The bench drives each pin at a falling clock edge and holds it for three clocks. It updates its reference model only after that settle window, with the per-clock comparison paused for the window. Between commits, the comparison on every clock also checks that the outputs stay stable during a shift.

// File: rtl/seg_rx_pkg.sv
package seg_rx_pkg;

  // decoded control fields held by slot A
  typedef struct packed {
    logic [2:0] port_sel;
    logic       duty_half;
    logic [2:0] frame_code;
    logic       osc_stop;
    logic       seg_blank;
    logic       pwr_save;
  } ctrl_t;

  localparam logic [7:0] DEF_DEV_ADDR = 8'h44;
  localparam int         DEF_A_DISP   = 28;
  localparam int         DEF_B_DISP   = 26;
  localparam int         DEF_STD_LEN  = 40;
  localparam int         DEF_CMP_LEN  = 32;

endpackage

// File: rtl/seg_rx_pins.sv
// Captures the link pins and derives single-cycle edge strobes.
module seg_rx_pins (
  input  logic clk,
  input  logic rst,
  input  logic ce,
  input  logic cl,
  input  logic di,
  output logic ce_lvl,
  output logic di_lvl,
  output logic cl_rise,
  output logic ce_rise,
  output logic ce_fall
);
  logic ce_prev, cl_lvl, cl_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_lvl  <= 1'b0;
      cl_lvl  <= 1'b0;
      di_lvl  <= 1'b0;
      ce_prev <= 1'b0;
      cl_prev <= 1'b0;
    end else begin
      ce_lvl  <= ce;
      cl_lvl  <= cl;
      di_lvl  <= di;
      ce_prev <= ce_lvl;
      cl_prev <= cl_lvl;
    end
  end

  assign cl_rise = cl_lvl & ~cl_prev;
  assign ce_rise = ce_lvl & ~ce_prev;
  assign ce_fall = ~ce_lvl & ce_prev;
endmodule

// File: rtl/seg_rx_shift.sv
// Address shift (ce low) and indexed data capture (ce high).
module seg_rx_shift #(
  parameter logic [7:0] DEV_ADDR = 8'h44,
  parameter int         STD_LEN  = 40,
  parameter int         CNT_W    = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               ce_lvl,
  input  logic               di_lvl,
  input  logic               cl_rise,
  input  logic               ce_rise,
  output logic [STD_LEN-1:0] frame,
  output logic [CNT_W-1:0]   cnt,
  output logic               addr_ok
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(STD_LEN);
  localparam logic [CNT_W-1:0] OVER = CNT_W'(STD_LEN + 1);

  logic [7:0] addr_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_sr <= '0;
      addr_ok <= 1'b0;
      cnt     <= '0;
      frame   <= '0;
    end else if (ce_rise) begin
      addr_ok <= (addr_sr == DEV_ADDR);
      addr_sr <= '0;
      cnt     <= '0;
    end else if (cl_rise) begin
      if (!ce_lvl) begin
        addr_sr <= {di_lvl, addr_sr[7:1]};
      end else if (cnt < FULL) begin
        frame[cnt] <= di_lvl;
        cnt        <= cnt + 1'b1;
      end else begin
        cnt <= OVER;  // saturate: any longer frame is rejected
      end
    end
  end
endmodule

// File: rtl/seg_rx_hold.sv
// Commits a completed frame to the holding registers and applies format forcing.
module seg_rx_hold
  import seg_rx_pkg::*;
#(
  parameter int A_DISP  = 28,
  parameter int B_DISP  = 26,
  parameter int STD_LEN = 40,
  parameter int CMP_LEN = 32,
  parameter int CNT_W   = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ce_fall,
  input  logic                     fmt_compact,
  input  logic [STD_LEN-1:0]       frame,
  input  logic [CNT_W-1:0]         cnt,
  input  logic                     addr_ok,
  output logic [A_DISP+B_DISP-1:0] disp,
  output ctrl_t                    ctrl
);
  localparam int POS_PORT = A_DISP + 1;
  localparam int POS_DUTY = POS_PORT + 3;
  localparam int POS_FC   = POS_DUTY + 1;
  localparam int POS_OC   = POS_FC + 3;
  localparam int POS_SC   = POS_OC + 1;
  localparam int POS_BU   = POS_SC + 1;
  localparam int CPOS_BU  = A_DISP;
  localparam int CPOS_SC  = A_DISP + 1;
  localparam logic [CNT_W-1:0] STD_CNT = CNT_W'(STD_LEN);
  localparam logic [CNT_W-1:0] CMP_CNT = CNT_W'(CMP_LEN);

  logic [A_DISP-1:0] disp_a;
  logic [B_DISP-1:0] disp_b;
  ctrl_t             held;
  logic              len_ok, dir, commit;

  assign len_ok = fmt_compact ? (cnt == CMP_CNT) : (cnt == STD_CNT);
  assign dir    = fmt_compact ? frame[CMP_LEN-1] : frame[STD_LEN-1];
  assign commit = ce_fall & addr_ok & len_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_a <= '0;
      disp_b <= '0;
      held   <= '0;
    end else if (commit) begin
      if (dir) begin
        disp_b <= frame[B_DISP-1:0];
      end else begin
        disp_a <= frame[A_DISP-1:0];
        if (fmt_compact) begin
          held.pwr_save  <= frame[CPOS_BU];
          held.seg_blank <= frame[CPOS_SC];
        end else begin
          held.port_sel   <= frame[POS_PORT +: 3];
          held.duty_half  <= frame[POS_DUTY];
          held.frame_code <= frame[POS_FC +: 3];
          held.osc_stop   <= frame[POS_OC];
          held.seg_blank  <= frame[POS_SC];
          held.pwr_save   <= frame[POS_BU];
        end
      end
    end
  end

  always_comb begin
    ctrl = held;
    if (fmt_compact) begin
      ctrl.port_sel   = 3'b000;
      ctrl.duty_half  = 1'b1;
      ctrl.frame_code = 3'b000;
      ctrl.osc_stop   = 1'b0;
    end
  end

  assign disp = {disp_b, disp_a};
endmodule

// File: rtl/seg_rx.sv
module seg_rx
  import seg_rx_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = DEF_DEV_ADDR,
  parameter int         A_DISP   = DEF_A_DISP,
  parameter int         B_DISP   = DEF_B_DISP,
  parameter int         STD_LEN  = DEF_STD_LEN,
  parameter int         CMP_LEN  = DEF_CMP_LEN
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fmt_compact,
  input  logic                     ce,
  input  logic                     cl,
  input  logic                     di,
  output logic [A_DISP+B_DISP-1:0] disp,
  output logic [2:0]               port_sel,
  output logic                     duty_half,
  output logic [2:0]               frame_code,
  output logic                     osc_stop,
  output logic                     seg_blank,
  output logic                     pwr_save
);
  localparam int CNT_W = $clog2(STD_LEN + 2);

  logic               ce_lvl, di_lvl, cl_rise, ce_rise, ce_fall;
  logic [STD_LEN-1:0] frame;
  logic [CNT_W-1:0]   cnt;
  logic               addr_ok;
  ctrl_t              ctrl;

  seg_rx_pins u_pins (
    .clk(clk), .rst(rst), .ce(ce), .cl(cl), .di(di),
    .ce_lvl(ce_lvl), .di_lvl(di_lvl), .cl_rise(cl_rise),
    .ce_rise(ce_rise), .ce_fall(ce_fall)
  );

  seg_rx_shift #(.DEV_ADDR(DEV_ADDR), .STD_LEN(STD_LEN), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst(rst), .ce_lvl(ce_lvl), .di_lvl(di_lvl),
    .cl_rise(cl_rise), .ce_rise(ce_rise),
    .frame(frame), .cnt(cnt), .addr_ok(addr_ok)
  );

  seg_rx_hold #(.A_DISP(A_DISP), .B_DISP(B_DISP), .STD_LEN(STD_LEN),
                .CMP_LEN(CMP_LEN), .CNT_W(CNT_W)) u_hold (
    .clk(clk), .rst(rst), .ce_fall(ce_fall), .fmt_compact(fmt_compact),
    .frame(frame), .cnt(cnt), .addr_ok(addr_ok),
    .disp(disp), .ctrl(ctrl)
  );

  assign port_sel   = ctrl.port_sel;
  assign duty_half  = ctrl.duty_half;
  assign frame_code = ctrl.frame_code;
  assign osc_stop   = ctrl.osc_stop;
  assign seg_blank  = ctrl.seg_blank;
  assign pwr_save   = ctrl.pwr_save;
endmodule

// File: rtl/seg_rx_chk.sv
module seg_rx_chk #(
  parameter int DISP_W  = 54,
  parameter int STD_LEN = 40,
  parameter int CNT_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              fmt_compact,
  input logic              ce_fall,
  input logic              addr_ok,
  input logic [CNT_W-1:0]  cnt,
  input logic [DISP_W-1:0] disp,
  input logic [2:0]        port_sel,
  input logic              duty_half,
  input logic [2:0]        frame_code,
  input logic              osc_stop,
  input logic              seg_blank,
  input logic              pwr_save
);
  logic pv;
  always_ff @(posedge clk) pv <= !rst;

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (disp == '0 && !seg_blank && !pwr_save));

  assert_commit_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (pv && !$stable(disp)) |-> $past(addr_ok));

  assert_compact_force_R6: assert property (@(posedge clk) disable iff (rst)
    fmt_compact |-> (port_sel == 3'b000 && duty_half && frame_code == 3'b000 && !osc_stop));

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(STD_LEN + 1));

  assert_disp_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(ce_fall)) |-> $stable(disp));

  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (pv && !$past(ce_fall) && $stable(fmt_compact)) |->
      $stable({port_sel, duty_half, frame_code, osc_stop, seg_blank, pwr_save}));
endmodule

bind seg_rx seg_rx_chk #(.DISP_W(A_DISP + B_DISP), .STD_LEN(STD_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .fmt_compact(fmt_compact), .ce_fall(ce_fall),
  .addr_ok(addr_ok), .cnt(cnt), .disp(disp), .port_sel(port_sel),
  .duty_half(duty_half), .frame_code(frame_code), .osc_stop(osc_stop),
  .seg_blank(seg_blank), .pwr_save(pwr_save)
);

// File: tb/seg_rx_tb.sv
`timescale 1ns/1ps
module seg_rx_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, fmt_compact = 1'b0, ce = 1'b0, cl = 1'b0, di = 1'b0;
  logic [53:0] disp;
  logic [2:0]  port_sel, frame_code;
  logic        duty_half, osc_stop, seg_blank, pwr_save;

  seg_rx u_dut (
    .clk(clk), .rst(rst), .fmt_compact(fmt_compact), .ce(ce), .cl(cl), .di(di),
    .disp(disp), .port_sel(port_sel), .duty_half(duty_half),
    .frame_code(frame_code), .osc_stop(osc_stop), .seg_blank(seg_blank),
    .pwr_save(pwr_save)
  );

  int total = 0, bad = 0;
  bit live = 0, busy = 0, done = 0;
  string tag = "R1";

  // reference model state
  logic [27:0] m_a = '0;
  logic [25:0] m_b = '0;
  logic [2:0]  m_port = '0, m_fc = '0;
  logic        m_duty = 0, m_oc = 0, m_sc = 0, m_bu = 0;

  task automatic cmp(input string t);
    logic [53:0] ed;
    logic [2:0]  ep, ef;
    logic        edt, eo;
    ed  = {m_b, m_a};
    ep  = fmt_compact ? 3'd0 : m_port;
    ef  = fmt_compact ? 3'd0 : m_fc;
    edt = fmt_compact ? 1'b1 : m_duty;
    eo  = fmt_compact ? 1'b0 : m_oc;
    total++;
    if (disp !== ed || port_sel !== ep || frame_code !== ef || duty_half !== edt ||
        osc_stop !== eo || seg_blank !== m_sc || pwr_save !== m_bu) begin
      bad++;
      $display("FAIL %s: got disp=%h p=%0d fc=%0d dt=%0b oc=%0b sc=%0b bu=%0b exp disp=%h p=%0d fc=%0d dt=%0b oc=%0b sc=%0b bu=%0b",
               t, disp, port_sel, frame_code, duty_half, osc_stop, seg_blank, pwr_save,
               ed, ep, ef, edt, eo, m_sc, m_bu);
    end
  endtask

  // per-clock comparison: outputs must track the model, i.e. hold between commits (R9)
  always @(negedge clk) if (live && !busy && !done) cmp({tag, "/R9"});

  task automatic tick();
    repeat (3) @(negedge clk);
  endtask

  task automatic pulse_bit(input logic b);
    di = b; tick();
    cl = 1'b1; tick();
    cl = 1'b0; tick();
  endtask

  task automatic send_raw(input logic [7:0] a, input logic [47:0] fr, input int n);
    ce = 1'b0; tick();
    for (int i = 0; i < 8; i++) pulse_bit(a[i]);
    ce = 1'b1; tick();
    for (int i = 0; i < n; i++) pulse_bit(fr[i]);
    busy = 1'b1;
    ce = 1'b0; tick();
  endtask

  function automatic logic [47:0] std_a(input logic [27:0] d, input logic [2:0] p,
      input logic dt, input logic [2:0] fc, input logic oc, input logic sc, input logic bu);
    logic [47:0] f = '0;
    f[27:0] = d; f[28] = 1'b1;  // ignored bit set to 1 on purpose
    f[31:29] = p; f[32] = dt; f[35:33] = fc;
    f[36] = oc; f[37] = sc; f[38] = bu; f[39] = 1'b0;
    return f;
  endfunction

  function automatic logic [47:0] std_b(input logic [25:0] d);
    logic [47:0] f = '0;
    f[25:0] = d; f[38:26] = 13'h1fff; f[39] = 1'b1;
    return f;
  endfunction

  function automatic logic [47:0] cmp_a(input logic [27:0] d, input logic bu, input logic sc);
    logic [47:0] f = '0;
    f[27:0] = d; f[28] = bu; f[29] = sc; f[31] = 1'b0;
    return f;
  endfunction

  function automatic logic [47:0] cmp_b(input logic [25:0] d);
    logic [47:0] f = '0;
    f[25:0] = d; f[31] = 1'b1;
    return f;
  endfunction

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    live = 1'b1;
    tag = "R1"; cmp("R1 reset");

    tag = "R3";
    send_raw(8'h44, std_a(28'h9A5_3C71, 3'd5, 1'b1, 3'd6, 1'b1, 1'b0, 1'b1), 40);
    m_a = 28'h9A5_3C71; m_port = 3'd5; m_duty = 1; m_fc = 3'd6; m_oc = 1; m_sc = 0; m_bu = 1;
    busy = 0; cmp("R3 std slot A");

    tag = "R4";
    send_raw(8'h44, std_b(26'h2B1_E4D3), 40);
    m_b = 26'h2B1_E4D3;
    busy = 0; cmp("R4 std slot B, R8 slot A kept");

    tag = "R8";
    send_raw(8'h44, std_a(28'h0F0_0FF1, 3'd2, 1'b0, 3'd1, 1'b0, 1'b1, 1'b0), 40);
    m_a = 28'h0F0_0FF1; m_port = 3'd2; m_duty = 0; m_fc = 3'd1; m_oc = 0; m_sc = 1; m_bu = 0;
    busy = 0; cmp("R8 slot A only, slot B kept; R3");

    tag = "R2";
    send_raw(8'h45, std_a(28'hFFF_FFFF, 3'd7, 1'b1, 3'd7, 1'b1, 1'b0, 1'b1), 40);
    busy = 0; cmp("R2 wrong address discarded");
    send_raw(8'h22, std_b(26'h3FF_FFFF), 40);
    busy = 0; cmp("R2 bit-reversed address discarded");

    tag = "R7";
    send_raw(8'h44, std_a(28'h123_4567, 3'd1, 1'b1, 3'd3, 1'b1, 1'b0, 1'b1), 39);
    busy = 0; cmp("R7 short frame discarded");
    send_raw(8'h44, std_b(26'h155_5555), 41);
    busy = 0; cmp("R7 long frame discarded");

    tag = "R6";
    fmt_compact = 1'b1;
    repeat (2) @(negedge clk);
    cmp("R6 compact forcing");

    tag = "R5";
    send_raw(8'h44, cmp_a(28'h5A5_A5A5, 1'b1, 1'b0), 32);
    m_a = 28'h5A5_A5A5; m_bu = 1; m_sc = 0;
    busy = 0; cmp("R5 compact slot A, R6");
    send_raw(8'h44, cmp_b(26'h0C3_3C3C), 32);
    m_b = 26'h0C3_3C3C;
    busy = 0; cmp("R5 compact slot B, R8");

    tag = "R7";
    send_raw(8'h44, std_a(28'h111_1111, 3'd4, 1'b0, 3'd2, 1'b1, 1'b1, 1'b0), 40);
    busy = 0; cmp("R7 standard length in compact discarded");
    send_raw(8'h44, cmp_b(26'h3FF_0000), 31);
    busy = 0; cmp("R7 compact short frame discarded");

    tag = "R6";
    fmt_compact = 1'b0;
    repeat (2) @(negedge clk);
    cmp("R6 standard fields return after compact");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule